// File: doc/BRIEF.md
# Two-Channel Sample Capture Buffer with Byte-Wide Host Port

This block takes samples from two converters that run without pause. On every sample strobe it packs the pair into one 36-bit storage word and pushes the word into an on-chip FIFO. The converters are never held back. A sample that arrives while the buffer is full is dropped, and a sticky flag records the loss.

A slow host drains the buffer through an 8-bit port. The byte under the read pointer is always visible on the port, and each host strobe steps to the next byte. One stored word takes five strobes, sent least significant byte first. Before a display refresh, the host pulses a flush. The flush throws away every stored word, any word that is part-way through being read, and the overflow record, so the next readout holds only fresh samples. Capture and readout run on the same clock.

Top module: `acq_fifo_top`

## Requirements
- R1: After reset, empty is 1, full is 0, overflow is 0 and rd_data is 8'h00.
- R2: A stored word holds channel A in bits [13:0], channel B in bits [27:14] and a 1 in bit 28, with bits [35:29] at zero.
- R3: A word is returned over five strobes, least significant byte first: bits [7:0], then [15:8], [23:16] and [31:24], then {4'b0, bits[35:32]}. The fifth byte's upper nibble is zero.
- R4: Words are read out in the order in which their samples were accepted.
- R5: full rises once DEPTH words are stored. A sample strobed while full is discarded and does not change any stored word.
- R6: overflow sets in the cycle after a sample strobe arrives while full. It stays set through reads until a flush.
- R7: After a flush, empty is 1 and overflow is 0. The next word is read from its byte 0. A sample strobed in the same cycle as the flush is discarded.
- R8: While empty, rd_data reads 8'h00 and a read strobe has no effect.
- R9: empty falls in the cycle after the first sample is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for capture and readout |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_strobe | input | 1 | One-cycle pulse: a sample pair is present |
| adc_a | input | 14 | Channel A sample |
| adc_b | input | 14 | Channel B sample |
| flush | input | 1 | Host refresh request; clears the buffer |
| rd_stb | input | 1 | Host strobe: step to the next byte |
| rd_data | output | 8 | Byte currently presented to the host |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Sticky: a sample was dropped since the last flush |

## Verification
The assertions assume that every input changes only between clock edges and holds a clean binary value once reset is released. They also assume a flush is a single-cycle request, not a level that is held for long. The bench drives every input at the falling edge and uses single-cycle pulses for flush, sample and read strobes. It runs with a shallow buffer, so the full and overflow conditions are reached within a few cycles. The assertions do not assume the host avoids reading an empty buffer, or avoids flushing and strobing in the same cycle, so the bench drives both cases on purpose.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int SMP_W    = 14;
  localparam int WORD_W   = 36;
  localparam int NBYTES   = 5;
  localparam int BIDX_W   = 3;
  localparam int VALID_AT = 2 * SMP_W;

  // Pack one sample pair into a storage word.
  function automatic logic [WORD_W-1:0] pack_pair(
    input logic [SMP_W-1:0] a,
    input logic [SMP_W-1:0] b
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[SMP_W-1:0]        = a;
    w[2*SMP_W-1:SMP_W]  = b;
    w[VALID_AT]         = 1'b1;
    return w;
  endfunction

  // Byte slice idx of a storage word, least significant first.
  function automatic logic [7:0] byte_of(
    input logic [WORD_W-1:0] w,
    input logic [BIDX_W-1:0] idx
  );
    logic [WORD_W-1:0] s;
    s = w >> {idx, 3'b000};
    return s[7:0];
  endfunction
endpackage

// File: rtl/acq_word_store.sv
module acq_word_store
  import acq_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [AW:0]       count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_MAX);
endmodule

// File: rtl/acq_byte_reader.sv
module acq_byte_reader
  import acq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_stb,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic [7:0]        rd_data,
  output logic              pop
);
  localparam logic [BIDX_W-1:0] LAST = BIDX_W'(NBYTES - 1);

  logic [BIDX_W-1:0] idx;
  logic              step;

  assign step    = rd_stb && !empty && !clr;
  assign pop     = step && (idx == LAST);
  assign rd_data = empty ? 8'h00 : byte_of(head, idx);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  idx <= '0;
    else if (pop)       idx <= '0;
    else if (step)      idx <= idx + 1'b1;
  end
endmodule

// File: rtl/acq_fifo_top.sv
module acq_fifo_top
  import acq_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_strobe,
  input  logic [SMP_W-1:0] adc_a,
  input  logic [SMP_W-1:0] adc_b,
  input  logic             flush,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  logic [WORD_W-1:0] packed_w, head_w;
  logic              wr_accept, wr_drop, rd_pop;

  assign packed_w  = pack_pair(adc_a, adc_b);
  assign wr_accept = adc_strobe && !full && !flush;
  assign wr_drop   = adc_strobe && full && !flush;

  acq_word_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .wr_en   (wr_accept),
    .wr_word (packed_w),
    .rd_en   (rd_pop),
    .head    (head_w),
    .empty   (empty),
    .full    (full)
  );

  acq_byte_reader u_reader (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .rd_stb  (rd_stb),
    .empty   (empty),
    .head    (head_w),
    .rd_data (rd_data),
    .pop     (rd_pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) overflow <= 1'b0;
    else if (wr_drop)    overflow <= 1'b1;
  end
endmodule

// File: rtl/acq_fifo_chk.sv
module acq_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_strobe,
  input logic       flush,
  input logic       rd_stb,
  input logic       empty,
  input logic       full,
  input logic       overflow,
  input logic       wr_accept,
  input logic       rd_pop
);
  // R5
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_pop && !flush |=> full);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);

  // R6
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(adc_strobe && full));

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overflow);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_stb && !adc_strobe |=> empty);

  // R9
  first_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !empty);

  // R1
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind acq_fifo_top acq_fifo_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_strobe (adc_strobe),
  .flush      (flush),
  .rd_stb     (rd_stb),
  .empty      (empty),
  .full       (full),
  .overflow   (overflow),
  .wr_accept  (wr_accept),
  .rd_pop     (rd_pop)
);

// File: tb/tb_acq_fifo_top.sv
module tb_acq_fifo_top;
  localparam int DEPTH = 8;
  localparam int NV    = 6;
  // each entry: {channel B, channel A}
  localparam logic [27:0] VEC [NV] = '{
    {14'h0000, 14'h0001}, {14'h3FFF, 14'h0000}, {14'h1234, 14'h2ABC},
    {14'h0155, 14'h2AAA}, {14'h3FFF, 14'h3FFF}, {14'h0F0F, 14'h30C3}
  };

  logic clk = 0, rst_n = 0;
  logic adc_strobe = 0, flush = 0, rd_stb = 0;
  logic [13:0] adc_a = '0, adc_b = '0;
  logic [7:0] rd_data;
  logic empty, full, overflow;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  acq_fifo_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .adc_strobe(adc_strobe), .adc_a(adc_a),
    .adc_b(adc_b), .flush(flush), .rd_stb(rd_stb), .rd_data(rd_data),
    .empty(empty), .full(full), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic [13:0] a, input logic [13:0] b,
                     input logic f, input logic r);
    @(negedge clk);
    adc_strobe = s; adc_a = a; adc_b = b; flush = f; rd_stb = r;
    @(posedge clk); #1;
    adc_strobe = 0; flush = 0; rd_stb = 0;
  endtask

  // expected byte k of a stored pair, built from the R2/R3 layout
  function automatic logic [7:0] exp_byte(input logic [13:0] a, input logic [13:0] b, input int k);
    logic [39:0] w;
    w = {4'h0, 7'h00, 1'b1, b, a};
    return w[k*8 +: 8];
  endfunction

  task automatic read_word(input string req, input logic [13:0] a, input logic [13:0] b);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(req, rd_data, exp_byte(a, b, k));
      if (k == 4) chk("R3", {rd_data[7:4], 4'h0}, 8'h00);
      cyc(0, '0, '0, 0, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", {5'b0, empty, full, overflow}, 8'b100);
    chk("R1", rd_data, 8'h00);
    rst_n = 1;

    // R2 R3 R4 R9: vector walk
    for (int i = 0; i < NV; i++) begin
      cyc(1, VEC[i][13:0], VEC[i][27:14], 0, 0);
      if (i == 0) chk("R9", {7'b0, empty}, 8'h00);
    end
    for (int i = 0; i < NV; i++) read_word("R2 R4", VEC[i][13:0], VEC[i][27:14]);
    @(negedge clk);
    chk("R4", {7'b0, empty}, 8'h01);

    // R5 R6: fill, then one extra sample
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); chk("R5", {7'b0, full}, 8'h00);
      cyc(1, 14'(i), ~14'(i), 0, 0);
    end
    @(negedge clk);
    chk("R5", {7'b0, full}, 8'h01);
    chk("R6", {7'b0, overflow}, 8'h00);
    cyc(1, 14'h3FFF, 14'h2222, 0, 0);
    @(negedge clk);
    chk("R6", {7'b0, overflow}, 8'h01);
    repeat (3) cyc(0, '0, '0, 0, 0);
    chk("R6", {7'b0, overflow}, 8'h01);
    for (int i = 0; i < DEPTH; i++) read_word("R5", 14'(i), ~14'(i));
    @(negedge clk);
    chk("R5", {7'b0, empty}, 8'h01);
    chk("R6", {7'b0, overflow}, 8'h01);

    // R7: flush mid-word with a simultaneous sample
    cyc(1, 14'h0AAA, 14'h0555, 0, 0);
    cyc(1, 14'h0BBB, 14'h0666, 0, 0);
    cyc(0, '0, '0, 0, 1);
    cyc(0, '0, '0, 0, 1);
    cyc(1, 14'h1111, 14'h1111, 1, 0);
    @(negedge clk);
    chk("R7", {6'b0, empty, overflow}, 8'b10);
    chk("R7", rd_data, 8'h00);
    cyc(1, 14'h2345, 14'h0123, 0, 0);
    read_word("R7", 14'h2345, 14'h0123);
    @(negedge clk);
    chk("R7", {7'b0, empty}, 8'h01);

    // R8: reads on an empty buffer are ignored
    cyc(0, '0, '0, 0, 1);
    cyc(0, '0, '0, 0, 1);
    @(negedge clk);
    chk("R8", rd_data, 8'h00);
    chk("R8", {7'b0, empty}, 8'h01);
    cyc(1, 14'h1ABC, 14'h2DEF, 0, 0);
    read_word("R8", 14'h1ABC, 14'h2DEF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule